// File: doc/BRIEF.md
# Page-One Hardware Stack Unit

This unit holds the stack pointer of an 8-bit processor with a 16-bit address bus and runs every stack access on the processor's behalf. The stack lives in one fixed 256-byte page, page one, at $0100 to $01FF, and it grows toward lower addresses. Each memory address is made by putting the 8-bit pointer below a constant high byte of $01.

The unit accepts one command at a time. It can push a byte, pull one, two or three bytes, load the pointer from an index-register value, or return the pointer. Multi-byte pulls, used for subroutine and interrupt returns, run as single-byte reads on back-to-back cycles. The unit drives a byte-wide memory port with at most one access per cycle, and the memory's read data is taken in the same cycle as the address. When a command finishes, the unit returns the pulled bytes and raises `done` for one cycle.

Top module: `stk_page_unit`

## Requirements
- R1: Every memory access (`mem_en` high) has address high byte $01, so it falls within $0100..$01FF.
- R2: After reset the pointer is $FF, and `busy`, `done` and `mem_en` are low.
- R3: Push (op code 1) makes one write at $0100 plus the pointer, with `mem_wdata` equal to the `cmd_data` given with the command, and then lowers the pointer by one. The access happens in the cycle after the command is accepted, and `done` is high in the cycle after the access.
- R4: Pull-one (op code 2) raises the pointer by one and then reads at $0100 plus the new pointer. The byte read appears in `result[7:0]` and `result[23:8]` is zero.
- R5: Pull-two (op code 3) reads two consecutive rising addresses on two consecutive cycles. The lower-addressed byte goes to `result[7:0]`, the next byte to `result[15:8]`, and `result[23:16]` is zero.
- R6: Pull-three (op code 4) reads three consecutive rising addresses on three consecutive cycles. Bytes go to `result[7:0]`, `[15:8]` and `[23:16]` in increasing address order.
- R7: The pointer wraps modulo 256. A push at pointer $00 leaves $FF, and a pull at pointer $FF reads $0100.
- R8: Load (op code 5) sets the pointer to `cmd_data`, makes no memory access, and raises `done` in the cycle after acceptance.
- R9: Read (op code 6) makes no memory access, leaves the pointer unchanged, and returns the pointer in `result[7:0]` with zero above it. `done` is high in the cycle after acceptance.
- R10: A command presented while `busy` is high is ignored and does not change the pointer.
- R11: A command makes exactly as many memory accesses as bytes it moves, and `mem_en` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_data | input | 8 | Push byte or pointer load value |
| busy | output | 1 | A multi-cycle command is running |
| done | output | 1 | One-cycle pulse: command finished |
| result | output | 24 | Pulled bytes or pointer readback |
| sp_out | output | 8 | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |

## Verification
The hardest cases to reach are pointer wraparound inside a multi-byte sequence, where a three-byte pull starts just below $FF and its later reads must fold back to $0100. A command that arrives during a running pull is another. The bench loads every one of the 256 pointer values in turn and pushes then pulls three, two and one byte from each, so every wrap position is met at each pull width. On some starting values it also drives a load command in the middle of a three-byte pull and checks that the pointer ignores it.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_PULL1 = 3'd2,
    OP_PULL2 = 3'd3,
    OP_PULL3 = 3'd4,
    OP_LOAD  = 3'd5,
    OP_READ  = 3'd6
  } stk_op_e;

  // number of memory accesses a command performs
  function automatic logic [1:0] op_accesses(input logic [2:0] op);
    case (op)
      OP_PUSH, OP_PULL1: op_accesses = 2'd1;
      OP_PULL2:          op_accesses = 2'd2;
      OP_PULL3:          op_accesses = 2'd3;
      default:           op_accesses = 2'd0;
    endcase
  endfunction

  function automatic logic op_is_write(input logic [2:0] op);
    op_is_write = (op == OP_PUSH);
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  output logic             accept,
  output logic             busy,
  output logic             step,
  output logic             step_wr,
  output logic             step_last,
  output logic [CNT_W-1:0] step_idx,
  output logic             done
);

  logic             run_q;
  logic [2:0]       op_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] acc_n;
  logic             instant;

  assign accept    = cmd_valid && !run_q;
  assign acc_n     = CNT_W'(op_accesses(cmd_op));
  assign instant   = (cmd_op == OP_LOAD) || (cmd_op == OP_READ);
  assign busy      = run_q;
  assign step      = run_q;
  assign step_wr   = run_q && op_is_write(op_q);
  assign step_last = run_q && (idx_q == total_q - CNT_W'(1));
  assign step_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      op_q    <= OP_NOP;
      idx_q   <= '0;
      total_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q  <= cmd_op;
        idx_q <= '0;
        if (acc_n != '0) begin
          run_q   <= 1'b1;
          total_q <= acc_n;
        end else if (instant) begin
          done <= 1'b1;
        end
      end else if (run_q) begin
        idx_q <= idx_q + CNT_W'(1);
        if (step_last) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int              PTR_W     = 8,
  parameter logic [PTR_W-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             dec_en,
  input  logic             inc_en,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_up
);

  // modulo-2^PTR_W step helpers
  function automatic logic [PTR_W-1:0] ptr_minus1(input logic [PTR_W-1:0] p);
    ptr_minus1 = p - PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_plus1(input logic [PTR_W-1:0] p);
    ptr_plus1 = p + PTR_W'(1);
  endfunction

  assign ptr_up = ptr_plus1(ptr);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= RESET_VAL;
    else if (load_en) ptr <= load_val;
    else if (dec_en)  ptr <= ptr_minus1(ptr);
    else if (inc_en)  ptr <= ptr_up;
  end

endmodule

// File: rtl/stk_collect.sv
module stk_collect #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     put_en,
  input  logic [IDX_W-1:0]         put_idx,
  input  logic [DATA_W-1:0]        put_byte,
  output logic [NBYTES*DATA_W-1:0] word
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        word[g*DATA_W +: DATA_W] <= '0;
      else if (put_en && (put_idx == IDX_W'(g)))
        word[g*DATA_W +: DATA_W] <= put_byte;
      else if (clear)
        word[g*DATA_W +: DATA_W] <= '0;
    end
  end

endmodule

// File: rtl/stk_page_unit.sv
module stk_page_unit
  import stk_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               PTR_W    = 8,
  parameter int               PAGE_W   = 8,
  parameter logic [PAGE_W-1:0] PAGE    = 8'h01,
  parameter int               MAX_PULL = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [DATA_W-1:0]          cmd_data,
  output logic                       busy,
  output logic                       done,
  output logic [MAX_PULL*DATA_W-1:0] result,
  output logic [PTR_W-1:0]           sp_out,
  output logic                       mem_en,
  output logic                       mem_we,
  output logic [PAGE_W+PTR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata
);

  localparam int CNT_W = $clog2(MAX_PULL + 1);

  // named internal events
  logic             evt_accept;
  logic             evt_step;
  logic             evt_push;
  logic             evt_pull;
  logic             evt_last;
  logic             evt_load;
  logic             evt_read;
  logic [CNT_W-1:0] step_idx;
  logic [PTR_W-1:0] ptr, ptr_up;
  logic [DATA_W-1:0] data_q;

  function automatic logic [PAGE_W+PTR_W-1:0] page_addr(input logic [PTR_W-1:0] p);
    page_addr = {PAGE, p};
  endfunction

  stk_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .accept(evt_accept), .busy(busy), .step(evt_step), .step_wr(evt_push),
    .step_last(evt_last), .step_idx(step_idx), .done(done)
  );

  assign evt_pull = evt_step && !evt_push;
  assign evt_load = evt_accept && (cmd_op == OP_LOAD);
  assign evt_read = evt_accept && (cmd_op == OP_READ);

  stk_ptr #(.PTR_W(PTR_W), .RESET_VAL('1)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(evt_load), .load_val(PTR_W'(cmd_data)),
    .dec_en(evt_push), .inc_en(evt_pull), .ptr(ptr), .ptr_up(ptr_up)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          data_q <= '0;
    else if (evt_accept) data_q <= cmd_data;
  end

  logic              put_en;
  logic [CNT_W-1:0]  put_idx;
  logic [DATA_W-1:0] put_byte;

  assign put_en   = evt_pull || evt_read;
  assign put_idx  = evt_read ? '0 : step_idx;
  assign put_byte = evt_read ? DATA_W'(ptr) : mem_rdata;

  stk_collect #(.DATA_W(DATA_W), .NBYTES(MAX_PULL), .IDX_W(CNT_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .clear(evt_accept), .put_en(put_en),
    .put_idx(put_idx), .put_byte(put_byte), .word(result)
  );

  assign sp_out    = ptr;
  assign mem_en    = evt_step;
  assign mem_we    = evt_push;
  assign mem_addr  = page_addr(evt_push ? ptr : ptr_up);
  assign mem_wdata = data_q;

endmodule

// File: rtl/stk_page_unit_chk.sv
module stk_page_unit_chk #(
  parameter int PTR_W  = 8,
  parameter int PAGE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic                    busy,
  input logic                    mem_en,
  input logic                    mem_we,
  input logic [PAGE_W+PTR_W-1:0] mem_addr,
  input logic [PTR_W-1:0]        sp_out
);

  AST_PAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr[PAGE_W+PTR_W-1:PTR_W] == PAGE_W'(1)); // R1

  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> mem_addr[PTR_W-1:0] == sp_out); // R3

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> sp_out == PTR_W'($past(sp_out) - 1'b1)); // R3

  AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> sp_out == PTR_W'($past(sp_out) + 1'b1)); // R4

  AST_PULL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> mem_addr[PTR_W-1:0] == PTR_W'(sp_out + 1'b1) || !mem_en); // R7

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en && !(cmd_valid && !busy && cmd_op == 3'd5)) |=> $stable(sp_out)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R11

endmodule

bind stk_page_unit stk_page_unit_chk #(.PTR_W(PTR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .sp_out(sp_out)
);

// File: tb/stk_page_unit_bench.sv
`timescale 1ns/1ps
module stk_page_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_data = 8'h00;
  logic        busy, done, mem_en, mem_we;
  logic [23:0] result;
  logic [7:0]  sp_out, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  logic [7:0] ram [256];
  logic [7:0] shadow [256];
  logic [7:0] sp_model;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stk_page_unit u_stk_page_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .result(result),
    .sp_out(sp_out), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: combinational read, write at the clock edge
  assign mem_rdata = ram[mem_addr[7:0]];
  always @(posedge clk) if (mem_en && mem_we) ram[mem_addr[7:0]] <= mem_wdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input int n,
                         input bit poke, input string req, output logic [23:0] res);
    int cyc = 0;
    int nacc = 0;
    bit wr = (op == 3'd1);
    logic [15:0] exp_a;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && cyc < 8) begin
      if (poke && cyc == 0) begin cmd_valid = 1'b1; cmd_op = 3'd5; cmd_data = 8'h00; end
      else if (poke && cyc == 1) cmd_valid = 1'b0;
      if (mem_en) begin
        exp_a = wr ? {8'h01, sp_model} : {8'h01, 8'(sp_model + 8'(nacc) + 8'd1)};
        check(mem_addr == exp_a, {req, " R1 address"}, 32'(mem_addr), 32'(exp_a));
        check(mem_we == wr, {req, " write enable"}, 32'(mem_we), 32'(wr));
        if (wr) check(mem_wdata == d, "R3 write data", 32'(mem_wdata), 32'(d));
        nacc++;
      end
      cyc++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(done == 1'b1, {req, " done"}, 32'(done), 32'd1);
    check(cyc == n, {req, " cycles to done"}, 32'(cyc), 32'(n));
    check(nacc == n, {req, " R11 access count"}, 32'(nacc), 32'(n));
    check(!busy, {req, " busy after done"}, 32'(busy), 32'd0);
    res = result;
    if (wr) begin shadow[sp_model] = d; sp_model = sp_model - 8'd1; end
    else if (op == 3'd5) sp_model = d;
    else sp_model = sp_model + 8'(n);
    check(sp_out == sp_model, {req, " pointer"}, 32'(sp_out), 32'(sp_model));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] r, e;
    logic [7:0] v0, v1, v2, base;
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R2: reset state
    check(sp_out == 8'hFF, "R2 pointer", 32'(sp_out), 32'hFF);
    check(!busy && !done && !mem_en, "R2 idle outputs", {29'd0, busy, done, mem_en}, 32'd0);
    rst_n = 1'b1;
    sp_model = 8'hFF;
    run_cmd(3'd6, 8'h00, 0, 0, "R9", r);
    check(r == 24'h0000FF, "R9 readback after reset", 32'(r), 32'hFF);

    for (int s = 0; s < 256; s++) begin
      run_cmd(3'd5, 8'(s), 0, 0, "R8", r);               // R8 load
      run_cmd(3'd6, 8'h00, 0, 0, "R9", r);               // R9 read
      check(r == {16'h0, 8'(s)}, "R9 readback", 32'(r), 32'(s));
      // three pushes then pull-three; wraps when s < 3 (R7)
      v0 = 8'(s) ^ 8'h5A; v1 = 8'(s * 3 + 7); v2 = ~8'(s);
      run_cmd(3'd1, v0, 1, 0, "R3", r);
      run_cmd(3'd1, v1, 1, 0, "R3", r);
      run_cmd(3'd1, v2, 1, 0, "R7", r);
      base = sp_model;
      e = {shadow[8'(base + 8'd3)], shadow[8'(base + 8'd2)], shadow[8'(base + 8'd1)]};
      run_cmd(3'd4, 8'h00, 3, (s % 64) == 5, "R6", r);   // poke also covers R10
      check(r == e, "R6 pulled bytes", 32'(r), 32'(e));
      check(r == {v0, v1, v2}, "R6 byte order", 32'(r), 32'({v0, v1, v2}));
      // two pushes then pull-two
      run_cmd(3'd1, v1 ^ 8'hC3, 1, 0, "R3", r);
      run_cmd(3'd1, v0 + 8'd9, 1, 0, "R3", r);
      run_cmd(3'd3, 8'h00, 2, 0, "R5", r);
      e = {8'h00, v1 ^ 8'hC3, v0 + 8'd9};
      check(r == e, "R5 pulled bytes", 32'(r), 32'(e));
      // one push then pull-one
      run_cmd(3'd1, v2 ^ 8'h81, 1, 0, "R3", r);
      run_cmd(3'd2, 8'h00, 1, 0, "R4", r);
      e = {16'h0, v2 ^ 8'h81};
      check(r == e, "R4 pulled byte", 32'(r), 32'(e));
      check(sp_out == 8'(s), "R10 pointer back at start", 32'(sp_out), 32'(s));
    end

    // R7: pull at $FF reads $0100
    run_cmd(3'd5, 8'hFF, 0, 0, "R8", r);
    run_cmd(3'd2, 8'h00, 1, 0, "R7", r);
    check(r == {16'h0, shadow[0]}, "R7 wrap read", 32'(r), 32'(shadow[0]));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule